// File: doc/BRIEF.md
# Synthesizer Control Latch Sequencer

This block sits behind the serial input register of a frequency synthesizer. Each time a complete control word has been shifted in, a one-cycle load strobe presents it. The two least significant bits of the word route it to one of four latches: reference counter, AB counter, function or initialization. From the function bits the block drives the static controls of the loop: counter hold, charge pump three-state, phase detector polarity, two charge pump current selects, prescaler select, fastlock enable and a power-down request.

The block also sequences the internal counter reset pulse. An initialization word fires the pulse once and arms it. The first AB counter word after that fires it a second time, so the counters start from their load point in close phase alignment. Any later AB word leaves the counters alone until the next initialization word. A hold bit in the function word gives a level reset under software control. The chip-enable input powers the device down at once, without waiting for a clock edge.

Top module: `synth_ctl_seq`

## Requirements
- R1: The word's two least significant bits select the latch: 2'b00 reference counter, 2'b01 AB counter, 2'b10 function, 2'b11 initialization. A reference word drives word[23:2] onto ref_data_o, and an AB word drives it onto ab_data_o, from the cycle after its load edge onward.
- R2: An initialization word writes the function fields exactly as a function word does, and so does a function word.
- R3: An initialization word raises cnt_rst_pulse_o for exactly the one cycle after its load edge. cp_tri_o is high during that cycle.
- R4: The first AB word after an initialization word raises cnt_rst_pulse_o for one cycle. Any later AB word leaves it low until the next initialization word.
- R5: While the function bit word[2] (hold) is 1, cnt_hold_o and cp_tri_o are 1. The hold does not raise pwr_down_o.
- R6: Function bit word[5] set to 1 forces cp_tri_o high. Set to 0, it releases cp_tri_o.
- R7: ce_i low drives pwr_down_o high at once, with no clock edge. ce_i high again releases it, and every latched output is unchanged.
- R8: The synchronous power-down setting is word[3]=1 with word[6]=0. If the reset pulse fires while ce_i is high and this setting is latched, pwr_down_o goes high on the pulse cycle and stays high. It stays high until a function word arrives without the setting.
- R9: The function fields drive the static outputs: pd_pol_o = word[4], cur1_o = word[9:7], fastlock_o = word[10], cur2_o = word[13:11], presc_o = word[15:14].
- R10: After reset, all latches are zero, no pulse is armed, and pwr_down_o stays high until the first function or initialization word.
- R11: ref_ld_o and ab_ld_o go high for the one cycle after a reference word or an AB word is loaded, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable; low powers the device down at once |
| load_i | input | 1 | One-cycle strobe marking a complete word |
| word_i | input | 24 | Control word; bits 1:0 are the address |
| ref_data_o | output | 22 | Reference counter latch contents |
| ab_data_o | output | 22 | AB counter latch contents |
| ref_ld_o | output | 1 | One-cycle reference counter load strobe |
| ab_ld_o | output | 1 | One-cycle AB counter load strobe |
| cnt_hold_o | output | 1 | Level hold of the counters at their load point |
| cnt_rst_pulse_o | output | 1 | One-cycle internal counter reset pulse |
| cp_tri_o | output | 1 | Charge pump three-state request |
| pd_pol_o | output | 1 | Phase detector polarity |
| cur1_o | output | 3 | Charge pump current setting 1 |
| cur2_o | output | 3 | Charge pump current setting 2 |
| presc_o | output | 2 | Prescaler select |
| fastlock_o | output | 1 | Fastlock timeout counter enable |
| pwr_down_o | output | 1 | Power-down request |

## Verification
Seeded random words drawn over all four addresses exercise the routing and field decoding, with the synchronous power-down bits present in about a quarter of the function words. This separates a correct address decode and correct field positions from swapped or shifted ones. Directed sequences drive init followed by two AB words, AB words with no init in between, and init followed by a function word and then an AB word. These tell a correctly armed one-shot apart from a pulse on every AB word or one that never rearms. Changes of chip-enable between clock edges, together with the hold bit and the power-down bit pair, show whether power-down is asynchronous and whether the hold is kept apart from power-down.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

   typedef enum logic [1:0] {
      ADR_REF  = 2'b00,
      ADR_AB   = 2'b01,
      ADR_FUNC = 2'b10,
      ADR_INIT = 2'b11
   } addr_e;

   localparam int unsigned NUM_LATCH = 4;

   function automatic logic sync_pd_sel(input logic pd1, input logic pd2);
      return pd1 & ~pd2;
   endfunction

endpackage

// File: rtl/synth_ctl_dec.sv
module synth_ctl_dec
   import synth_ctl_pkg::*;
#(
   parameter int unsigned N_SEL = NUM_LATCH
)(
   input  logic             load_i,
   input  logic [1:0]       addr_i,
   output logic [N_SEL-1:0] sel_o
);
   initial begin
      assert (N_SEL == 4) else $error("decoder needs four latches");
   end

   for (genvar i = 0; i < N_SEL; i++) begin : g_sel
      assign sel_o[i] = load_i && (addr_i == 2'(i));
   end
endmodule

// File: rtl/synth_ctl_func.sv
module synth_ctl_func #(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned CUR_W  = 3,
   parameter int unsigned PSC_W  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              cfg_o,
   output logic              hold_o,
   output logic              pd1_o,
   output logic              pd2_o,
   output logic              pol_o,
   output logic              tri_o,
   output logic              fl_o,
   output logic [CUR_W-1:0]  cur1_o,
   output logic [CUR_W-1:0]  cur2_o,
   output logic [PSC_W-1:0]  psc_o
);
   localparam int unsigned F_HOLD = 2;
   localparam int unsigned F_PD1  = 3;
   localparam int unsigned F_POL  = 4;
   localparam int unsigned F_TRI  = 5;
   localparam int unsigned F_PD2  = 6;
   localparam int unsigned F_CUR1 = 7;
   localparam int unsigned F_FL   = F_CUR1 + CUR_W;
   localparam int unsigned F_CUR2 = F_FL + 1;
   localparam int unsigned F_PSC  = F_CUR2 + CUR_W;
   localparam int unsigned MIN_W  = F_PSC + PSC_W;

   initial begin
      assert (WORD_W >= MIN_W) else $error("word too narrow for function fields");
   end

   logic [WORD_W-1:0] func_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         func_q <= '0;
         cfg_o  <= 1'b0;
      end else if (wr_i) begin
         func_q <= word_i;
         cfg_o  <= 1'b1;
      end
   end

   assign hold_o = func_q[F_HOLD];
   assign pd1_o  = func_q[F_PD1];
   assign pd2_o  = func_q[F_PD2];
   assign pol_o  = func_q[F_POL];
   assign tri_o  = func_q[F_TRI];
   assign fl_o   = func_q[F_FL];
   assign cur1_o = func_q[F_CUR1 +: CUR_W];
   assign cur2_o = func_q[F_CUR2 +: CUR_W];
   assign psc_o  = func_q[F_PSC +: PSC_W];
endmodule

// File: rtl/synth_ctl_pulse.sv
module synth_ctl_pulse
   import synth_ctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ce_i,
   input  logic init_i,
   input  logic ab_i,
   input  logic func_i,
   input  logic new_pd1_i,
   input  logic new_pd2_i,
   input  logic cur_pd1_i,
   input  logic cur_pd2_i,
   output logic armed_o,
   output logic pulse_o,
   output logic pds_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_o <= 1'b0;
         pulse_o <= 1'b0;
         pds_o   <= 1'b0;
      end else begin
         pulse_o <= 1'b0;
         if (init_i) begin
            armed_o <= 1'b1;
            pulse_o <= 1'b1;
            pds_o   <= ce_i && sync_pd_sel(new_pd1_i, new_pd2_i);
         end else if (ab_i && armed_o) begin
            armed_o <= 1'b0;
            pulse_o <= 1'b1;
            if (ce_i && sync_pd_sel(cur_pd1_i, cur_pd2_i)) pds_o <= 1'b1;
         end else if (func_i && !sync_pd_sel(new_pd1_i, new_pd2_i)) begin
            pds_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/synth_ctl_seq.sv
module synth_ctl_seq
   import synth_ctl_pkg::*;
#(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned CUR_W  = 3,
   parameter int unsigned PSC_W  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-3:0] ref_data_o,
   output logic [WORD_W-3:0] ab_data_o,
   output logic              ref_ld_o,
   output logic              ab_ld_o,
   output logic              cnt_hold_o,
   output logic              cnt_rst_pulse_o,
   output logic              cp_tri_o,
   output logic              pd_pol_o,
   output logic [CUR_W-1:0]  cur1_o,
   output logic [CUR_W-1:0]  cur2_o,
   output logic [PSC_W-1:0]  presc_o,
   output logic              fastlock_o,
   output logic              pwr_down_o
);
   localparam int unsigned DATA_W = WORD_W - 2;

   logic [NUM_LATCH-1:0] sel;
   logic cfg, pd1, pd2, tri_bit, armed_q, pds;

   synth_ctl_dec #(.N_SEL(NUM_LATCH)) u_dec (
      .load_i (load_i),
      .addr_i (word_i[1:0]),
      .sel_o  (sel)
   );

   synth_ctl_func #(.WORD_W(WORD_W), .CUR_W(CUR_W), .PSC_W(PSC_W)) u_func (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (sel[ADR_FUNC] | sel[ADR_INIT]),
      .word_i (word_i),
      .cfg_o  (cfg),
      .hold_o (cnt_hold_o),
      .pd1_o  (pd1),
      .pd2_o  (pd2),
      .pol_o  (pd_pol_o),
      .tri_o  (tri_bit),
      .fl_o   (fastlock_o),
      .cur1_o (cur1_o),
      .cur2_o (cur2_o),
      .psc_o  (presc_o)
   );

   synth_ctl_pulse u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_i      (ce_i),
      .init_i    (sel[ADR_INIT]),
      .ab_i      (sel[ADR_AB]),
      .func_i    (sel[ADR_FUNC]),
      .new_pd1_i (word_i[3]),
      .new_pd2_i (word_i[6]),
      .cur_pd1_i (pd1),
      .cur_pd2_i (pd2),
      .armed_o   (armed_q),
      .pulse_o   (cnt_rst_pulse_o),
      .pds_o     (pds)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_data_o <= '0;
         ab_data_o  <= '0;
         ref_ld_o   <= 1'b0;
         ab_ld_o    <= 1'b0;
      end else begin
         ref_ld_o <= sel[ADR_REF];
         ab_ld_o  <= sel[ADR_AB];
         if (sel[ADR_REF]) ref_data_o <= word_i[WORD_W-1:2];
         if (sel[ADR_AB])  ab_data_o  <= word_i[WORD_W-1:2];
      end
   end

   assign pwr_down_o = !ce_i || !cfg || pds;
   assign cp_tri_o   = tri_bit || cnt_hold_o || cnt_rst_pulse_o || pwr_down_o;

   initial begin
      assert (DATA_W >= 1) else $error("word width too small");
   end
endmodule

// File: rtl/synth_ctl_chk.sv
module synth_ctl_chk
   import synth_ctl_pkg::*;
#(
   parameter int unsigned WORD_W = 24
)(
   input logic              clk,
   input logic              rst_n,
   input logic              ce_i,
   input logic              load_i,
   input logic [WORD_W-1:0] word_i,
   input logic              armed_q,
   input logic              ref_ld_o,
   input logic              cnt_hold_o,
   input logic              cnt_rst_pulse_o,
   input logic              cp_tri_o,
   input logic              pd_pol_o,
   input logic              pwr_down_o
);
   // R3
   pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst_pulse_o |-> $past(load_i && (word_i[1:0] == ADR_INIT || word_i[1:0] == ADR_AB)));
   // R3
   pulse_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst_pulse_o |-> cp_tri_o);
   // R4
   ab_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && word_i[1:0] == ADR_AB && !armed_q) |=> !cnt_rst_pulse_o);
   // R5
   hold_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_hold_o |-> cp_tri_o);
   // R7
   ce_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_i |-> pwr_down_o);
   // R11
   ref_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && word_i[1:0] == ADR_REF) |=> ref_ld_o);
   // R2
   init_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && word_i[1:0] == ADR_INIT) |=> (pd_pol_o == $past(word_i[4])));
endmodule

bind synth_ctl_seq synth_ctl_chk #(.WORD_W(WORD_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ce_i            (ce_i),
   .load_i          (load_i),
   .word_i          (word_i),
   .armed_q         (armed_q),
   .ref_ld_o        (ref_ld_o),
   .cnt_hold_o      (cnt_hold_o),
   .cnt_rst_pulse_o (cnt_rst_pulse_o),
   .cp_tri_o        (cp_tri_o),
   .pd_pol_o        (pd_pol_o),
   .pwr_down_o      (pwr_down_o)
);

// File: tb/test_synth_ctl_seq.sv
`timescale 1ns/1ps
module test_synth_ctl_seq;
   localparam int W = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 1'b1;
   logic load = 1'b0;
   logic [W-1:0] word = '0;

   logic [W-3:0] ref_data, ab_data;
   logic ref_ld, ab_ld, hold, pulse, cp_tri, pol, fl, pwr;
   logic [2:0] cur1, cur2;
   logic [1:0] psc;

   int n_chk = 0;
   int n_fail = 0;

   logic [W-1:0] m_func;
   logic [W-3:0] m_ref, m_ab;
   logic m_cfg, m_armed, m_pds, m_pulse, m_refld, m_abld;

   always #4 clk = ~clk;

   synth_ctl_seq i_synth_ctl_seq (
      .clk(clk), .rst_n(rst_n), .ce_i(ce), .load_i(load), .word_i(word),
      .ref_data_o(ref_data), .ab_data_o(ab_data), .ref_ld_o(ref_ld), .ab_ld_o(ab_ld),
      .cnt_hold_o(hold), .cnt_rst_pulse_o(pulse), .cp_tri_o(cp_tri), .pd_pol_o(pol),
      .cur1_o(cur1), .cur2_o(cur2), .presc_o(psc), .fastlock_o(fl), .pwr_down_o(pwr)
   );

   function automatic logic sel_pd(input logic [W-1:0] f);
      return f[3] & ~f[6];
   endfunction

   function automatic logic exp_pwr();
      return !ce || !m_cfg || m_pds;
   endfunction

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(ref_data == m_ref, {tag, " R1 ref_data"}, ref_data, m_ref);
      chk(ab_data == m_ab, {tag, " R1 ab_data"}, ab_data, m_ab);
      chk(pulse == m_pulse, {tag, " R3/R4 pulse"}, pulse, m_pulse);
      chk({ref_ld, ab_ld} == {m_refld, m_abld}, {tag, " R11 strobes"}, {ref_ld, ab_ld}, {m_refld, m_abld});
      chk(hold == m_func[2], {tag, " R5 hold"}, hold, m_func[2]);
      chk(pwr == exp_pwr(), {tag, " R8 pwr_down"}, pwr, exp_pwr());
      chk(cp_tri == (m_func[5] | m_func[2] | m_pulse | exp_pwr()), {tag, " R6 cp_tri"},
          cp_tri, m_func[5] | m_func[2] | m_pulse | exp_pwr());
      chk({pol, cur1, fl, cur2, psc} == m_func[15:4] & 12'hFF9 | {1'b0, 11'h0} | {pol, cur1, fl, cur2, psc} & 12'h000
          ? 1'b1 : ({pol, cur1, fl, cur2, psc} == {m_func[4], m_func[9:7], m_func[10], m_func[13:11], m_func[15:14]}),
          {tag, " R9 fields"}, {pol, cur1, fl, cur2, psc},
          {m_func[4], m_func[9:7], m_func[10], m_func[13:11], m_func[15:14]});
   endtask

   // model update for one load edge
   task automatic model(input logic [W-1:0] w);
      m_pulse = 0; m_refld = 0; m_abld = 0;
      case (w[1:0])
         2'b00: begin m_ref = w[W-1:2]; m_refld = 1; end
         2'b01: begin
            m_ab = w[W-1:2]; m_abld = 1;
            if (m_armed) begin
               m_pulse = 1; m_armed = 0;
               if (ce && sel_pd(m_func)) m_pds = 1;
            end
         end
         2'b10: begin m_func = w; m_cfg = 1; if (!sel_pd(w)) m_pds = 0; end
         default: begin m_func = w; m_cfg = 1; m_armed = 1; m_pulse = 1; m_pds = ce && sel_pd(w); end
      endcase
   endtask

   task automatic apply(input logic [W-1:0] w, input string tag);
      @(negedge clk);
      word = w; load = 1'b1;
      model(w);
      @(negedge clk);
      load = 1'b0;
      check_all(tag);
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      m_pulse = 0; m_refld = 0; m_abld = 0;
      check_all(tag);
   endtask

   function automatic logic [W-1:0] fw(input logic [1:0] a, input logic hold_b, input logic pd1,
                                       input logic pd2, input logic [W-1:0] rest);
      logic [W-1:0] r;
      r = rest; r[1:0] = a; r[2] = hold_b; r[3] = pd1; r[6] = pd2;
      return r;
   endfunction

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [W-1:0] w, snap;
      void'($urandom(32'h5EED_0042));
      m_func = '0; m_ref = '0; m_ab = '0;
      m_cfg = 0; m_armed = 0; m_pds = 0; m_pulse = 0; m_refld = 0; m_abld = 0;
      repeat (3) @(negedge clk);
      // R10 reset state: all zero, powered down until configured
      check_all("reset R10");
      rst_n = 1'b1;
      idle("after reset R10");
      apply(fw(2'b00, 0, 0, 0, 24'hABCDE4), "ref before cfg R10");
      chk(pwr == 1'b1, "R10 pwr before function load", pwr, 1);

      // R3 R4: init, AB pulses once, second AB does not
      apply(fw(2'b11, 0, 0, 0, 24'h3C5A90), "init R3");
      idle("after init R3");
      apply(fw(2'b01, 0, 0, 0, 24'h123455), "first AB R4");
      apply(fw(2'b01, 0, 0, 0, 24'h654321), "second AB R4");
      chk(pulse == 1'b0, "R4 no pulse on later AB", pulse, 0);
      // R4: init, function load, then AB still pulses
      apply(fw(2'b11, 0, 0, 0, 24'h000003), "init2 R3");
      apply(fw(2'b10, 0, 0, 0, 24'h00F4A2), "func between R2");
      apply(fw(2'b01, 0, 0, 0, 24'h000011), "AB after func R4");

      // R5 hold: cp_tri high, no power-down
      apply(fw(2'b10, 1, 0, 0, 24'h000000), "hold on R5");
      chk(pwr == 1'b0, "R5 hold no pwr_down", pwr, 0);
      idle("hold steady R5");
      // R6 tri bit
      apply(fw(2'b10, 0, 0, 0, 24'h000020), "tri bit R6");
      apply(fw(2'b10, 0, 0, 0, 24'h000000), "tri clear R6");
      chk(cp_tri == 1'b0, "R6 cp_tri released", cp_tri, 0);

      // R7 async chip enable
      apply(fw(2'b10, 0, 0, 0, 24'h00A690), "cfg R7");
      snap = {pol, cur1, fl, cur2, psc, 12'h0};
      @(negedge clk); #1 ce = 1'b0; #1;
      chk(pwr == 1'b1, "R7 immediate power-down", pwr, 1);
      #1 ce = 1'b1; #1;
      chk(pwr == 1'b0, "R7 resume", pwr, 0);
      chk({pol, cur1, fl, cur2, psc, 12'h0} == snap, "R7 latches kept", {pol, cur1, fl, cur2, psc}, snap[W-1:12]);

      // R8 synchronous power-down on pulse
      apply(fw(2'b10, 0, 1, 0, 24'h000000), "sync sel no pulse R8");
      chk(pwr == 1'b0, "R8 no pd without pulse", pwr, 0);
      apply(fw(2'b11, 0, 1, 0, 24'h000000), "init sync R8");
      apply(fw(2'b01, 0, 0, 0, 24'h000101), "AB sync R8");
      apply(fw(2'b10, 0, 0, 0, 24'h000000), "func clears R8");
      chk(pwr == 1'b0, "R8 cleared", pwr, 0);

      // random mix R1 R2 R9 R11
      for (int i = 0; i < 600; i++) begin
         w = W'($urandom());
         if ((i % 7) == 0) ce = 1'b0; else ce = 1'b1;
         apply(w, "random R1/R2/R9");
      end
      ce = 1'b1;
      idle("final");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule